// File: doc/BRIEF.md
# Decode-Stage Operand Bypass and Hazard Stall Unit

This block sits in the decode stage of a five-stage 32-bit pipeline. For each of the two source register indices of the instruction being decoded, it chooses the operand value. The value comes either from the register file read port or from a result that is still travelling down the pipe. There are three such in-flight points: the execute output, the memory-access output and the writeback input. Each one presents a destination register index, a data word and a flag that says whether the data word already exists.

When an in-flight result targets a register that decode needs but its data is not ready yet, the unit requests a stall and lowers the stage ready signal. The typical case is a load still in execute, which knows its target but not its data. The unit is purely combinational, so operands and stall settle in the same cycle as the inputs. It holds no state, so it has no state machine. The older stages, the register file and the ALU are outside the block and appear only as inputs.

Top module: `fwdu_top`

## Requirements
- R1: A source index of 0 always yields an operand of zero and never contributes to a stall, whatever the in-flight destinations are. A destination of 0 is the null target used by idle or non-writing stages, and it never forwards.
- R2: A nonzero source index that matches no in-flight destination yields the register file value for that operand, with no stall.
- R3: A nonzero source index equal to the execute destination, with the execute data flag high, yields the execute data word.
- R4: When several in-flight destinations equal the source index, the youngest one decides: execute first, then memory-access, then writeback. The memory-access data is used only when execute does not match, and the writeback data only when neither execute nor memory-access matches.
- R5: When the deciding match has its data flag low, stall_req is 1 and stage_ready is 0. The operand value is then unspecified.
- R6: A match with its data flag low that is shadowed by a younger match whose data flag is high causes no stall.
- R7: The two operands are resolved independently of each other. stall_req is the OR of the two per-operand stall conditions.
- R8: stage_ready is always the inverse of stall_req, in the same cycle as the inputs, with no register in the path.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rs1_idx | input | 5 | First source register index |
| rs2_idx | input | 5 | Second source register index |
| rf_rs1 | input | 32 | Register file value for the first source |
| rf_rs2 | input | 32 | Register file value for the second source |
| ex_dst | input | 5 | Execute output destination index (0 = none) |
| ex_val | input | 32 | Execute output data |
| ex_ok | input | 1 | Execute output data present |
| ma_dst | input | 5 | Memory-access output destination index (0 = none) |
| ma_val | input | 32 | Memory-access output data |
| ma_ok | input | 1 | Memory-access output data present |
| wb_dst | input | 5 | Writeback input destination index (0 = none) |
| wb_val | input | 32 | Writeback input data |
| wb_ok | input | 1 | Writeback input data present |
| opnd_a | output | 32 | Resolved first operand |
| opnd_b | output | 32 | Resolved second operand |
| stall_req | output | 1 | Hazard stall request |
| stage_ready | output | 1 | Decode stage ready (low while stalled) |

## Verification
The sweep covers every mix of destinations over a small set of register indices, with every combination of data flags, for both operands at once. A wrong priority order would deliver older data when all three sources match. A picker that looked at every match, and not only the winning one, would stall when a younger valid result shadows a stale load (R6). Letting index 0 match would turn reads of the zero register into forwarded garbage or false stalls. Coupling the operands would show up as a stall or value on one operand that follows the other operand's hazard.

// File: rtl/fwdu_pkg.sv
package fwdu_pkg;
    localparam int REG_AW  = 5;
    localparam int DATA_W  = 32;
    localparam int NUM_SRC = 3;   // order is age: 0 = youngest (execute)
    localparam int NUM_OPS = 2;
endpackage

// File: rtl/fwdu_hit_vec.sv
module fwdu_hit_vec #(
    parameter int AW = fwdu_pkg::REG_AW,
    parameter int NS = fwdu_pkg::NUM_SRC
) (
    input  logic [AW-1:0]         idx,
    input  logic [NS-1:0][AW-1:0] dst,
    output logic [NS-1:0]         hit
);
    logic idx_live;

    assign idx_live = (idx != '0);

    genvar gi;
    generate
        for (gi = 0; gi < NS; gi++) begin : g_cmp
            assign hit[gi] = idx_live && (dst[gi] == idx);
        end
    endgenerate
endmodule

// File: rtl/fwdu_pick.sv
module fwdu_pick #(
    parameter int NS = fwdu_pkg::NUM_SRC
) (
    input  logic [NS-1:0] hit,
    output logic [NS-1:0] sel,
    output logic          any
);
    logic taken;

    always_comb begin
        sel   = '0;
        taken = 1'b0;
        for (int i = 0; i < NS; i++) begin
            if (hit[i] && !taken) begin
                sel[i] = 1'b1;
                taken  = 1'b1;
            end
        end
        any = taken;
    end
endmodule

// File: rtl/fwdu_operand.sv
module fwdu_operand #(
    parameter int AW = fwdu_pkg::REG_AW,
    parameter int DW = fwdu_pkg::DATA_W,
    parameter int NS = fwdu_pkg::NUM_SRC
) (
    input  logic [AW-1:0]         idx,
    input  logic [DW-1:0]         rf_val,
    input  logic [NS-1:0][AW-1:0] dst,
    input  logic [NS-1:0][DW-1:0] val,
    input  logic [NS-1:0]         ok,
    output logic [DW-1:0]         opnd,
    output logic                  stall
);
    logic [NS-1:0] hit;
    logic [NS-1:0] sel;
    logic          any;
    logic [DW-1:0] fwd_val;
    logic          win_ok;

    fwdu_hit_vec #(.AW(AW), .NS(NS)) u_hit (
        .idx (idx),
        .dst (dst),
        .hit (hit)
    );

    fwdu_pick #(.NS(NS)) u_pick (
        .hit (hit),
        .sel (sel),
        .any (any)
    );

    always_comb begin
        fwd_val = '0;
        for (int i = 0; i < NS; i++) begin
            fwd_val = fwd_val | ({DW{sel[i]}} & val[i]);
        end
    end

    assign win_ok = |(sel & ok);
    assign stall  = any && !win_ok;

    always_comb begin
        if (idx == '0)
            opnd = '0;
        else if (any && win_ok)
            opnd = fwd_val;
        else
            opnd = rf_val;
    end
endmodule

// File: rtl/fwdu_top.sv
module fwdu_top #(
    parameter int AW = fwdu_pkg::REG_AW,
    parameter int DW = fwdu_pkg::DATA_W
) (
    input  logic [AW-1:0] rs1_idx,
    input  logic [AW-1:0] rs2_idx,
    input  logic [DW-1:0] rf_rs1,
    input  logic [DW-1:0] rf_rs2,
    input  logic [AW-1:0] ex_dst,
    input  logic [DW-1:0] ex_val,
    input  logic          ex_ok,
    input  logic [AW-1:0] ma_dst,
    input  logic [DW-1:0] ma_val,
    input  logic          ma_ok,
    input  logic [AW-1:0] wb_dst,
    input  logic [DW-1:0] wb_val,
    input  logic          wb_ok,
    output logic [DW-1:0] opnd_a,
    output logic [DW-1:0] opnd_b,
    output logic          stall_req,
    output logic          stage_ready
);
    localparam int NS = fwdu_pkg::NUM_SRC;
    localparam int NO = fwdu_pkg::NUM_OPS;

    logic [NS-1:0][AW-1:0] src_dst;
    logic [NS-1:0][DW-1:0] src_val;
    logic [NS-1:0]         src_ok;
    logic [NO-1:0][AW-1:0] op_idx;
    logic [NO-1:0][DW-1:0] op_rf;
    logic [NO-1:0][DW-1:0] op_out;
    logic [NO-1:0]         op_stall;

    // index order sets priority: execute, memory-access, writeback
    assign src_dst = {wb_dst, ma_dst, ex_dst};
    assign src_val = {wb_val, ma_val, ex_val};
    assign src_ok  = {wb_ok,  ma_ok,  ex_ok};

    assign op_idx = {rs2_idx, rs1_idx};
    assign op_rf  = {rf_rs2, rf_rs1};

    genvar go;
    generate
        for (go = 0; go < NO; go++) begin : g_op
            fwdu_operand #(.AW(AW), .DW(DW), .NS(NS)) u_op (
                .idx    (op_idx[go]),
                .rf_val (op_rf[go]),
                .dst    (src_dst),
                .val    (src_val),
                .ok     (src_ok),
                .opnd   (op_out[go]),
                .stall  (op_stall[go])
            );
        end
    endgenerate

    assign opnd_a      = op_out[0];
    assign opnd_b      = op_out[1];
    assign stall_req   = |op_stall;
    assign stage_ready = !stall_req;
endmodule

// File: rtl/fwdu_check.sv
module fwdu_check #(
    parameter int AW = 5,
    parameter int DW = 32
) (
    input logic [AW-1:0] rs1_idx,
    input logic [AW-1:0] rs2_idx,
    input logic [DW-1:0] rf_rs1,
    input logic [AW-1:0] ex_dst,
    input logic [DW-1:0] ex_val,
    input logic          ex_ok,
    input logic [AW-1:0] ma_dst,
    input logic [AW-1:0] wb_dst,
    input logic [DW-1:0] opnd_a,
    input logic [DW-1:0] opnd_b,
    input logic          stall_req,
    input logic          stage_ready
);
    logic known;
    logic a_live;
    logic a_nomatch;

    assign known = !$isunknown({rs1_idx, rs2_idx, rf_rs1, ex_dst, ex_val, ex_ok,
                                ma_dst, wb_dst, opnd_a, opnd_b, stall_req, stage_ready});
    assign a_live    = (rs1_idx != '0);
    assign a_nomatch = (ex_dst != rs1_idx) && (ma_dst != rs1_idx) && (wb_dst != rs1_idx);

    always_comb begin
        if (known) begin
            a_r1_zero_a: assert (rs1_idx != '0 || opnd_a == '0)
                else $error("zero index A gave nonzero operand");
            a_r1_zero_b: assert (rs2_idx != '0 || opnd_b == '0)
                else $error("zero index B gave nonzero operand");
            a_r2_regfile: assert (!(a_live && a_nomatch) || opnd_a == rf_rs1)
                else $error("unmatched operand A not from register file");
            a_r3_exec_fwd: assert (!(a_live && ex_dst == rs1_idx && ex_ok) || opnd_a == ex_val)
                else $error("execute match not forwarded on A");
            a_r5_load_stall: assert (!(a_live && ex_dst == rs1_idx && !ex_ok) || stall_req)
                else $error("pending execute result did not stall");
            a_r8_ready_inv: assert (stage_ready == !stall_req)
                else $error("ready not inverse of stall");
        end
    end
endmodule

bind fwdu_top fwdu_check #(.AW(AW), .DW(DW)) u_chk (
    .rs1_idx     (rs1_idx),
    .rs2_idx     (rs2_idx),
    .rf_rs1      (rf_rs1),
    .ex_dst      (ex_dst),
    .ex_val      (ex_val),
    .ex_ok       (ex_ok),
    .ma_dst      (ma_dst),
    .wb_dst      (wb_dst),
    .opnd_a      (opnd_a),
    .opnd_b      (opnd_b),
    .stall_req   (stall_req),
    .stage_ready (stage_ready)
);

// File: tb/fwdu_top_test.sv
`timescale 1ns/1ps
module fwdu_top_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;   // 50 MHz

    logic [4:0]  rs1_idx = '0, rs2_idx = '0;
    logic [31:0] rf_rs1 = '0, rf_rs2 = '0;
    logic [4:0]  ex_dst = '0, ma_dst = '0, wb_dst = '0;
    logic [31:0] ex_val = '0, ma_val = '0, wb_val = '0;
    logic        ex_ok = 1'b0, ma_ok = 1'b0, wb_ok = 1'b0;
    logic [31:0] opnd_a, opnd_b;
    logic        stall_req, stage_ready;

    int total = 0;
    int bad = 0;
    bit done = 0;

    fwdu_top uut (
        .rs1_idx(rs1_idx), .rs2_idx(rs2_idx), .rf_rs1(rf_rs1), .rf_rs2(rf_rs2),
        .ex_dst(ex_dst), .ex_val(ex_val), .ex_ok(ex_ok),
        .ma_dst(ma_dst), .ma_val(ma_val), .ma_ok(ma_ok),
        .wb_dst(wb_dst), .wb_val(wb_val), .wb_ok(wb_ok),
        .opnd_a(opnd_a), .opnd_b(opnd_b),
        .stall_req(stall_req), .stage_ready(stage_ready)
    );

    // reference: returns {stall, value}
    function automatic logic [32:0] ref_op(input logic [4:0] idx, input logic [31:0] rf);
        if (idx == 5'd0)     return {1'b0, 32'd0};
        if (ex_dst == idx)   return ex_ok ? {1'b0, ex_val} : {1'b1, rf};
        if (ma_dst == idx)   return ma_ok ? {1'b0, ma_val} : {1'b1, rf};
        if (wb_dst == idx)   return wb_ok ? {1'b0, wb_val} : {1'b1, rf};
        return {1'b0, rf};
    endfunction

    function automatic string tag_of(input logic [4:0] idx, input logic [32:0] r);
        if (idx == 5'd0)   return "R1";
        if (r[32])         return "R5";
        if (ex_dst == idx) return "R3";
        if (ma_dst == idx || wb_dst == idx) return "R4";
        return "R2";
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic settle();
        #5;
    endtask

    task automatic set_src(input logic [4:0] ed, input logic eo, input logic [4:0] md,
                           input logic mo, input logic [4:0] wd, input logic wo);
        ex_dst = ed; ex_ok = eo; ma_dst = md; ma_ok = mo; wb_dst = wd; wb_ok = wo;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        logic [32:0] ea, eb;
        repeat (2) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        settle();
        // all-zero inputs
        check("R1 idle opnd_a", opnd_a, 32'd0);
        check("R1 idle opnd_b", opnd_b, 32'd0);
        check("R8 idle ready", {31'd0, stage_ready}, 32'd1);

        ex_val = 32'hE0E0_0001; ma_val = 32'hA0A0_0002; wb_val = 32'hB0B0_0003;
        rf_rs1 = 32'h1111_1111; rf_rs2 = 32'h2222_2222;

        // R1: index zero with null targets all invalid
        @(negedge clk); rs1_idx = 0; rs2_idx = 0; set_src(0, 0, 0, 0, 0, 0); settle();
        check("R1 zero no stall", {31'd0, stall_req}, 32'd0);
        check("R1 zero operand", opnd_a, 32'd0);
        // R2
        @(negedge clk); rs1_idx = 7; rs2_idx = 9; set_src(3, 1, 4, 1, 5, 1); settle();
        check("R2 rf a", opnd_a, rf_rs1);
        check("R2 rf b", opnd_b, rf_rs2);
        // R3
        @(negedge clk); rs1_idx = 7; set_src(7, 1, 0, 0, 0, 0); settle();
        check("R3 exec fwd", opnd_a, ex_val);
        // R4 all match
        @(negedge clk); set_src(7, 1, 7, 1, 7, 1); settle();
        check("R4 exec wins", opnd_a, ex_val);
        @(negedge clk); set_src(1, 1, 7, 1, 7, 1); settle();
        check("R4 mem wins", opnd_a, ma_val);
        @(negedge clk); set_src(1, 1, 2, 1, 7, 1); settle();
        check("R4 wb used", opnd_a, wb_val);
        // R5 load in execute
        @(negedge clk); set_src(7, 0, 7, 1, 7, 1); settle();
        check("R5 load stall", {31'd0, stall_req}, 32'd1);
        check("R5 ready low", {31'd0, stage_ready}, 32'd0);
        // R6 shadowed stale
        @(negedge clk); set_src(7, 1, 7, 0, 7, 0); settle();
        check("R6 no stall", {31'd0, stall_req}, 32'd0);
        check("R6 value", opnd_a, ex_val);
        // R7 independence
        @(negedge clk); rs1_idx = 7; rs2_idx = 9; set_src(7, 0, 9, 1, 0, 0); settle();
        check("R7 stall from A", {31'd0, stall_req}, 32'd1);
        check("R7 B still fwd", opnd_b, ma_val);
        @(negedge clk); rs1_idx = 9; rs2_idx = 7; settle();
        check("R7 A fwd", opnd_a, ma_val);
        check("R7 stall from B", {31'd0, stall_req}, 32'd1);

        // near-exhaustive sweep over indices 0..3
        for (int c = 0; c < 512; c++) begin
            for (int a = 0; a < 4; a++) begin
                for (int b = 0; b < 4; b++) begin
                    @(negedge clk);
                    set_src(5'(c[2:1]), c[0], 5'(c[5:4]), c[3], 5'(c[8:7]), c[6]);
                    ex_val = 32'hE000_0000 | 32'(c);
                    ma_val = 32'hD000_0000 | 32'(c);
                    wb_val = 32'hC000_0000 | 32'(c);
                    rf_rs1 = 32'h1000_0000 | 32'(a);
                    rf_rs2 = 32'h2000_0000 | 32'(b);
                    rs1_idx = 5'(a); rs2_idx = 5'(b);
                    settle();
                    ea = ref_op(rs1_idx, rf_rs1);
                    eb = ref_op(rs2_idx, rf_rs2);
                    if (!ea[32]) check({tag_of(rs1_idx, ea), " sweep A"}, opnd_a, ea[31:0]);
                    if (!eb[32]) check({tag_of(rs2_idx, eb), " sweep B"}, opnd_b, eb[31:0]);
                    check("R7 sweep stall", {31'd0, stall_req}, {31'd0, ea[32] | eb[32]});
                    check("R8 sweep ready", {31'd0, stage_ready}, {31'd0, !(ea[32] | eb[32])});
                end
            end
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule